// File: doc/BRIEF.md
# SD Host Block Transfer DMA Engine

This engine moves whole data blocks between the card-side data buffer of an SD host and system memory without processor involvement. Software fills a small register file with the transfer direction, the addressing style (stepping or fixed), a 64-bit start address split over two 32-bit registers, a block size and a block count, then sets a start bit. The engine moves `count * size / 4` 32-bit words, one memory request at a time, and raises a sticky completion flag for the direction that ran.

Card-to-memory transfers take words from the buffer through a valid/ready pair and write each one to memory through a request/grant port; memory-to-card transfers read memory through the same port and offer each word to the buffer through a second valid/ready pair. A misaligned address or an empty transfer is rejected with a sticky error flag and no data movement. Each status register has a mask register, and a single interrupt line reports any unmasked flag. Per-direction channel reset bits abort a transfer that is under way.

Top module: `sddma_top`

## Requirements
- R1: After reset both status registers read 0, both mask registers read 0xFFFFFFFF, the interrupt is low and no memory request, buffer ready or buffer valid is driven.
- R2: With mode bit 16 set (card to memory) and mode bit 0 set (stepping), each word accepted from the buffer is written to memory at the start address plus 4 per word already moved.
- R3: With mode bit 16 clear (memory to card) and stepping on, words read from consecutive memory addresses (step 4) are offered to the buffer in address order.
- R4: With mode bit 0 clear (fixed), every word of the transfer uses the start address.
- R5: A transfer moves exactly block count times block size divided by 4 words, the block size register being offset 9 and the block count register offset 10; the start address is {offset 8, offset 7}.
- R6: A start is a write of bit 0 at offset 1 (control); it is acted on only when bit 1 of offset 11 (DMA enable) is set and no transfer is running, and the control register always reads 0.
- R7: A start with address bits [3:0] not zero or with a word count of zero sets the error bit for the programmed direction in status register 2 (offset 5: bit 17 card to memory, bit 16 memory to card) one cycle after the start write, and moves no data.
- R8: Status register 1 (offset 3) bit 20 is set one cycle after the grant of the final memory write of a card-to-memory transfer, bit 16 one cycle after the final word is taken by the buffer in a memory-to-card transfer, and neither is set earlier.
- R9: Status register 1 bit 17 is set one cycle after the final word is taken from the buffer in a card-to-memory transfer, even while that word's memory write is still waiting for a grant.
- R10: Status bits are sticky; a register write clears each status bit whose written value is 0 and leaves bits written as 1 unchanged.
- R11: The interrupt is high exactly when some status bit is set whose bit in the matching mask register (offset 4 for status 1, offset 6 for status 2) is 0.
- R12: Writing bit 9 of offset 2 aborts a running card-to-memory transfer and bit 8 a running memory-to-card one, with no completion flag; the bit for the other direction has no effect.
- R13: A memory request keeps its address, data and direction until granted, and an offered buffer word stays unchanged until taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| dma_irq | output | 1 | Any unmasked status bit set |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_gnt |
| buf_rd_valid | input | 1 | Buffer has a card word |
| buf_rd_ready | output | 1 | Engine takes the card word |
| buf_rd_data | input | 32 | Card word |
| buf_wr_valid | output | 1 | Engine offers a word to the card side |
| buf_wr_ready | input | 1 | Buffer takes the offered word |
| buf_wr_data | output | 32 | Word for the card side |

## Verification
Register writes land on the clock edge after the strobe is raised, so a start or an error flag appears in the cycle right after that edge; the bench reads status at the falling edge that follows its write task and at no other time for R7. Completion flags lag the final handshake by exactly one edge, so the completion test stalls the grant, samples the flags at falling edges while the last write is pending, then releases the grant for one edge and expects bit 20 at the very next falling edge. Memory contents and buffer words are checked only after the completion flag has been observed, and stalled states for the abort test are confirmed through buffer ready before and after each reset write.

// File: rtl/sddma_pkg.sv
package sddma_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 64;
    localparam int REG_W   = 32;
    localparam int RA_W    = 4;
    localparam int CNT_W   = 32;
    localparam int SIZE_W  = 16;
    localparam int LEN_W   = CNT_W + SIZE_W;
    localparam int WORD_SH = $clog2(DATA_W / 8);

    typedef enum logic [RA_W-1:0] {
        RG_MODE   = 4'd0,
        RG_CTRL   = 4'd1,
        RG_CHRST  = 4'd2,
        RG_STAT1  = 4'd3,
        RG_MASK1  = 4'd4,
        RG_STAT2  = 4'd5,
        RG_MASK2  = 4'd6,
        RG_ADDRLO = 4'd7,
        RG_ADDRHI = 4'd8,
        RG_BSIZE  = 4'd9,
        RG_BCOUNT = 4'd10,
        RG_XMODE  = 4'd11
    } reg_sel_e;

    // bit positions decoded by software
    localparam int B_DIR       = 16;
    localparam int B_INC       = 0;
    localparam int B_START     = 0;
    localparam int B_RST_C2M   = 9;
    localparam int B_RST_M2C   = 8;
    localparam int B_DONE_C2M  = 20;
    localparam int B_EARLY_C2M = 17;
    localparam int B_DONE_M2C  = 16;
    localparam int B_ERR_C2M   = 17;
    localparam int B_ERR_M2C   = 16;
    localparam int B_DMA_EN    = 1;

    typedef struct packed {
        logic              to_mem;
        logic              incr;
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  words;
    } xfer_cfg_t;

    typedef struct packed {
        logic done_c2m;
        logic done_m2c;
        logic early_c2m;
        logic err_c2m;
        logic err_m2c;
    } xfer_evt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_C2M_TAKE,
        ST_C2M_STORE,
        ST_M2C_LOAD,
        ST_M2C_GIVE
    } eng_state_e;

    function automatic logic [LEN_W-1:0] word_count(
        input logic [CNT_W-1:0]  blocks,
        input logic [SIZE_W-1:0] bytes_per_block
    );
        logic [LEN_W-1:0] total;
        total = LEN_W'(blocks) * LEN_W'(bytes_per_block);
        return total >> WORD_SH;
    endfunction

endpackage

// File: rtl/sddma_regs.sv
module sddma_regs
    import sddma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  xfer_evt_t        evt,
    output xfer_cfg_t        cfg,
    output logic             start,
    output logic             abort_c2m,
    output logic             abort_m2c,
    output logic             irq
);

    logic              mode_dir, mode_inc, dma_en;
    logic [REG_W-1:0]  mask1, mask2, addr_lo, addr_hi;
    logic [SIZE_W-1:0] bsize;
    logic [CNT_W-1:0]  bcount;
    logic              s_done_c2m, s_done_m2c, s_early_c2m;
    logic              s_err_c2m, s_err_m2c;
    logic [REG_W-1:0]  stat1_v, stat2_v;
    logic              wr_st1, wr_st2;

    assign wr_st1 = reg_we && (reg_addr == RG_STAT1);
    assign wr_st2 = reg_we && (reg_addr == RG_STAT2);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_dir    <= 1'b0;
            mode_inc    <= 1'b0;
            dma_en      <= 1'b0;
            mask1       <= '1;
            mask2       <= '1;
            addr_lo     <= '0;
            addr_hi     <= '0;
            bsize       <= '0;
            bcount      <= '0;
            s_done_c2m  <= 1'b0;
            s_done_m2c  <= 1'b0;
            s_early_c2m <= 1'b0;
            s_err_c2m   <= 1'b0;
            s_err_m2c   <= 1'b0;
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    RG_MODE: begin
                        mode_dir <= reg_wdata[B_DIR];
                        mode_inc <= reg_wdata[B_INC];
                    end
                    RG_MASK1:  mask1   <= reg_wdata;
                    RG_MASK2:  mask2   <= reg_wdata;
                    RG_ADDRLO: addr_lo <= reg_wdata;
                    RG_ADDRHI: addr_hi <= reg_wdata;
                    RG_BSIZE:  bsize   <= reg_wdata[SIZE_W-1:0];
                    RG_BCOUNT: bcount  <= reg_wdata[CNT_W-1:0];
                    RG_XMODE:  dma_en  <= reg_wdata[B_DMA_EN];
                    default: ;
                endcase
            end
            // new events win over a clearing write in the same cycle
            s_done_c2m  <= evt.done_c2m  | (s_done_c2m  & ~(wr_st1 & ~reg_wdata[B_DONE_C2M]));
            s_done_m2c  <= evt.done_m2c  | (s_done_m2c  & ~(wr_st1 & ~reg_wdata[B_DONE_M2C]));
            s_early_c2m <= evt.early_c2m | (s_early_c2m & ~(wr_st1 & ~reg_wdata[B_EARLY_C2M]));
            s_err_c2m   <= evt.err_c2m   | (s_err_c2m   & ~(wr_st2 & ~reg_wdata[B_ERR_C2M]));
            s_err_m2c   <= evt.err_m2c   | (s_err_m2c   & ~(wr_st2 & ~reg_wdata[B_ERR_M2C]));
        end
    end

    always_comb begin
        stat1_v              = '0;
        stat1_v[B_DONE_C2M]  = s_done_c2m;
        stat1_v[B_EARLY_C2M] = s_early_c2m;
        stat1_v[B_DONE_M2C]  = s_done_m2c;
        stat2_v              = '0;
        stat2_v[B_ERR_C2M]   = s_err_c2m;
        stat2_v[B_ERR_M2C]   = s_err_m2c;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RG_MODE: begin
                reg_rdata[B_DIR] = mode_dir;
                reg_rdata[B_INC] = mode_inc;
            end
            RG_STAT1:  reg_rdata = stat1_v;
            RG_MASK1:  reg_rdata = mask1;
            RG_STAT2:  reg_rdata = stat2_v;
            RG_MASK2:  reg_rdata = mask2;
            RG_ADDRLO: reg_rdata = addr_lo;
            RG_ADDRHI: reg_rdata = addr_hi;
            RG_BSIZE:  reg_rdata = REG_W'(bsize);
            RG_BCOUNT: reg_rdata = REG_W'(bcount);
            RG_XMODE:  reg_rdata[B_DMA_EN] = dma_en;
            default:   reg_rdata = '0;
        endcase
    end

    assign cfg.to_mem = mode_dir;
    assign cfg.incr   = mode_inc;
    assign cfg.base   = {addr_hi, addr_lo};
    assign cfg.words  = word_count(bcount, bsize);

    assign start     = reg_we && (reg_addr == RG_CTRL) && reg_wdata[B_START] && dma_en;
    assign abort_c2m = reg_we && (reg_addr == RG_CHRST) && reg_wdata[B_RST_C2M];
    assign abort_m2c = reg_we && (reg_addr == RG_CHRST) && reg_wdata[B_RST_M2C];

    assign irq = (|(stat1_v & ~mask1)) | (|(stat2_v & ~mask2));

endmodule

// File: rtl/sddma_engine.sv
module sddma_engine
    import sddma_pkg::*;
#(
    parameter int ALIGN_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_cfg_t         cfg,
    input  logic              abort_c2m,
    input  logic              abort_m2c,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              buf_rd_valid,
    output logic              buf_rd_ready,
    input  logic [DATA_W-1:0] buf_rd_data,
    output logic              buf_wr_valid,
    input  logic              buf_wr_ready,
    output logic [DATA_W-1:0] buf_wr_data,
    output xfer_evt_t         evt
);

    localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);
    localparam int STEP      = DATA_W / 8;

    eng_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;
    logic [DATA_W-1:0] hold_q;
    logic              inc_q;
    logic              bad_cfg, last, accept;
    logic [ADDR_W-1:0] addr_next;

    assign bad_cfg   = (|cfg.base[ALIGN_LSB-1:0]) || (cfg.words == '0);
    assign last      = (left_q == LEN_W'(1));
    assign accept    = (state == ST_IDLE) && start;
    assign addr_next = inc_q ? addr_q + ADDR_W'(STEP) : addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            left_q <= '0;
            hold_q <= '0;
            inc_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept && !bad_cfg) begin
                        addr_q <= cfg.base;
                        left_q <= cfg.words;
                        inc_q  <= cfg.incr;
                        state  <= cfg.to_mem ? ST_C2M_TAKE : ST_M2C_LOAD;
                    end
                end
                ST_C2M_TAKE: begin
                    if (abort_c2m) begin
                        state <= ST_IDLE;
                    end else if (buf_rd_valid) begin
                        hold_q <= buf_rd_data;
                        state  <= ST_C2M_STORE;
                    end
                end
                ST_C2M_STORE: begin
                    if (abort_c2m) begin
                        state <= ST_IDLE;
                    end else if (mem_gnt) begin
                        if (last) begin
                            state <= ST_IDLE;
                        end else begin
                            left_q <= left_q - LEN_W'(1);
                            addr_q <= addr_next;
                            state  <= ST_C2M_TAKE;
                        end
                    end
                end
                ST_M2C_LOAD: begin
                    if (abort_m2c) begin
                        state <= ST_IDLE;
                    end else if (mem_gnt) begin
                        hold_q <= mem_rdata;
                        state  <= ST_M2C_GIVE;
                    end
                end
                ST_M2C_GIVE: begin
                    if (abort_m2c) begin
                        state <= ST_IDLE;
                    end else if (buf_wr_ready) begin
                        if (last) begin
                            state <= ST_IDLE;
                        end else begin
                            left_q <= left_q - LEN_W'(1);
                            addr_q <= addr_next;
                            state  <= ST_M2C_LOAD;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req      = (state == ST_C2M_STORE) || (state == ST_M2C_LOAD);
    assign mem_we       = (state == ST_C2M_STORE);
    assign mem_addr     = addr_q;
    assign mem_wdata    = hold_q;
    assign buf_rd_ready = (state == ST_C2M_TAKE);
    assign buf_wr_valid = (state == ST_M2C_GIVE);
    assign buf_wr_data  = hold_q;

    assign evt.err_c2m   = accept && bad_cfg && cfg.to_mem;
    assign evt.err_m2c   = accept && bad_cfg && !cfg.to_mem;
    assign evt.early_c2m = (state == ST_C2M_TAKE) && buf_rd_valid && last && !abort_c2m;
    assign evt.done_c2m  = (state == ST_C2M_STORE) && mem_gnt && last && !abort_c2m;
    assign evt.done_m2c  = (state == ST_M2C_GIVE) && buf_wr_ready && last && !abort_m2c;

endmodule

// File: rtl/sddma_top.sv
module sddma_top
    import sddma_pkg::*;
#(
    parameter int ALIGN_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              dma_irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              buf_rd_valid,
    output logic              buf_rd_ready,
    input  logic [DATA_W-1:0] buf_rd_data,
    output logic              buf_wr_valid,
    input  logic              buf_wr_ready,
    output logic [DATA_W-1:0] buf_wr_data
);

    xfer_cfg_t cfg;
    xfer_evt_t evt;
    logic      start_pulse, abort_c2m, abort_m2c, abort_any;

    assign abort_any = abort_c2m | abort_m2c;

    sddma_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt       (evt),
        .cfg       (cfg),
        .start     (start_pulse),
        .abort_c2m (abort_c2m),
        .abort_m2c (abort_m2c),
        .irq       (dma_irq)
    );

    sddma_engine #(.ALIGN_BYTES(ALIGN_BYTES)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .start        (start_pulse),
        .cfg          (cfg),
        .abort_c2m    (abort_c2m),
        .abort_m2c    (abort_m2c),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_gnt      (mem_gnt),
        .mem_rdata    (mem_rdata),
        .buf_rd_valid (buf_rd_valid),
        .buf_rd_ready (buf_rd_ready),
        .buf_rd_data  (buf_rd_data),
        .buf_wr_valid (buf_wr_valid),
        .buf_wr_ready (buf_wr_ready),
        .buf_wr_data  (buf_wr_data),
        .evt          (evt)
    );

endmodule

// File: rtl/sddma_chk.sv
module sddma_chk
    import sddma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              buf_rd_valid,
    input logic              buf_rd_ready,
    input logic              buf_wr_valid,
    input logic              buf_wr_ready,
    input logic [DATA_W-1:0] buf_wr_data,
    input logic              abort_any,
    input xfer_evt_t         evt
);

    // R13: an ungranted request holds its address, data and kind
    p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt && !abort_any |=>
            mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));

    // R13: an offered buffer word waits unchanged until taken
    p_word_hold_r13: assert property (@(posedge clk) disable iff (rst)
        buf_wr_valid && !buf_wr_ready && !abort_any |=>
            buf_wr_valid && $stable(buf_wr_data));

    // R7: a rejected start leaves both data paths idle
    p_err_no_move_r7: assert property (@(posedge clk) disable iff (rst)
        (evt.err_c2m || evt.err_m2c) |=> !mem_req && !buf_rd_ready && !buf_wr_valid);

    // R8: card-to-memory completion only on a granted write
    p_done_c2m_gnt_r8: assert property (@(posedge clk) disable iff (rst)
        evt.done_c2m |-> mem_req && mem_we && mem_gnt);

    // R8: memory-to-card completion only on a taken word
    p_done_m2c_take_r8: assert property (@(posedge clk) disable iff (rst)
        evt.done_m2c |-> buf_wr_valid && buf_wr_ready);

    // R9: early flag only on a buffer handshake
    p_early_take_r9: assert property (@(posedge clk) disable iff (rst)
        evt.early_c2m |-> buf_rd_valid && buf_rd_ready);

    // R2: at most one side of the engine active
    p_one_side_r2: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_req, buf_rd_ready, buf_wr_valid}) <= 1);

endmodule

bind sddma_top sddma_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_gnt      (mem_gnt),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .buf_rd_valid (buf_rd_valid),
    .buf_rd_ready (buf_rd_ready),
    .buf_wr_valid (buf_wr_valid),
    .buf_wr_ready (buf_wr_ready),
    .buf_wr_data  (buf_wr_data),
    .abort_any    (abort_any),
    .evt          (evt)
);

// File: tb/sddma_top_bench.sv
module sddma_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    localparam logic [3:0] A_MODE = 4'd0, A_CTRL = 4'd1, A_CHRST = 4'd2,
        A_STAT1 = 4'd3, A_MASK1 = 4'd4, A_STAT2 = 4'd5, A_MASK2 = 4'd6,
        A_LO = 4'd7, A_HI = 4'd8, A_BSIZE = 4'd9, A_BCOUNT = 4'd10, A_XMODE = 4'd11;
    localparam logic [31:0] M_C2M = 32'h0001_0000, M_INC = 32'h1;

    logic        clk = 1'b0, rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        dma_irq, mem_req, mem_we, mem_gnt;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata, buf_rd_data, buf_wr_data;
    logic        buf_rd_valid, buf_rd_ready, buf_wr_valid, buf_wr_ready;

    logic        gnt_en = 1'b1, src_en = 1'b1, snk_en = 1'b1, clr_req = 1'b0;
    logic [31:0] mem [0:63];
    logic [31:0] sink [0:15];
    logic [31:0] src_idx;
    int          sink_n;
    int          checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sddma_top u_sddma_top (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_irq(dma_irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .buf_rd_valid(buf_rd_valid), .buf_rd_ready(buf_rd_ready),
        .buf_rd_data(buf_rd_data), .buf_wr_valid(buf_wr_valid),
        .buf_wr_ready(buf_wr_ready), .buf_wr_data(buf_wr_data)
    );

    assign mem_gnt      = mem_req & gnt_en;
    assign mem_rdata    = mem[mem_addr[7:2]];
    assign buf_rd_valid = src_en;
    assign buf_rd_data  = 32'hA000_0000 + src_idx;
    assign buf_wr_ready = snk_en;

    always @(posedge clk) begin
        if (clr_req) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'hC0DE_0000 | i;
            src_idx <= '0;
            sink_n  <= 0;
        end else begin
            if (mem_req && mem_gnt && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
            if (buf_rd_valid && buf_rd_ready) src_idx <= src_idx + 1;
            if (buf_wr_valid && buf_wr_ready) begin
                sink[sink_n[3:0]] <= buf_wr_data;
                sink_n <= sink_n + 1;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_bit(input logic [3:0] a, input int b, output logic seen);
        logic [31:0] v;
        seen = 1'b0;
        for (int k = 0; k < 200 && !seen; k++) begin
            @(negedge clk);
            rd(a, v);
            seen = v[b];
        end
    endtask

    task automatic fresh;
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
        gnt_en = 1'b1; src_en = 1'b1; snk_en = 1'b1;
        wr(A_STAT1, 32'h0);
        wr(A_STAT2, 32'h0);
    endtask

    task automatic setup(input logic [31:0] mode, input logic [31:0] lo,
                         input logic [31:0] hi, input logic [31:0] size,
                         input logic [31:0] cnt);
        wr(A_MODE, mode); wr(A_LO, lo); wr(A_HI, hi);
        wr(A_BSIZE, size); wr(A_BCOUNT, cnt);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        @(negedge clk);
        rd(A_STAT1, v); check("R1", "status1 after reset", v, 0);
        rd(A_STAT2, v); check("R1", "status2 after reset", v, 0);
        rd(A_MASK1, v); check("R1", "mask1 after reset", v, 32'hFFFF_FFFF);
        rd(A_MASK2, v); check("R1", "mask2 after reset", v, 32'hFFFF_FFFF);
        check("R1", "irq/req/ready/valid after reset",
              {dma_irq, mem_req, buf_rd_ready, buf_wr_valid}, 0);
    endtask

    task automatic t_c2m_inc;
        logic seen; logic [31:0] v;
        fresh();
        setup(M_C2M | M_INC, 32'h20, 0, 8, 2);
        wr(A_CTRL, 1);
        wait_bit(A_STAT1, 20, seen);
        check("R2", "card-to-memory completion seen", seen, 1);
        for (int i = 0; i < 4; i++)
            check("R2", "stepped memory word", mem[8+i], 32'hA000_0000 + i);
        check("R5", "word after length untouched", mem[12], 32'hC0DE_000C);
        check("R5", "words taken from buffer", src_idx, 4);
        rd(A_STAT1, v);
        check("R9", "legacy flag set with completion", v[17], 1);
        check("R8", "other-direction completion clear", v[16], 0);
        rd(A_CTRL, v);
        check("R6", "control reads zero", v, 0);
    endtask

    task automatic t_m2c_inc;
        logic seen;
        fresh();
        setup(M_INC, 32'h80, 0, 4, 3);
        wr(A_CTRL, 1);
        wait_bit(A_STAT1, 16, seen);
        check("R3", "memory-to-card completion seen", seen, 1);
        @(negedge clk);
        check("R5", "words offered to buffer", sink_n, 3);
        for (int i = 0; i < 3; i++)
            check("R3", "buffer word in address order", sink[i], 32'hC0DE_0000 | (32 + i));
    endtask

    task automatic t_fixed;
        logic seen;
        fresh();
        setup(M_C2M, 32'h40, 0, 4, 3);
        wr(A_CTRL, 1);
        wait_bit(A_STAT1, 20, seen);
        check("R4", "fixed transfer complete", seen, 1);
        check("R4", "fixed address holds last word", mem[16], 32'hA000_0002);
        check("R4", "next address untouched", mem[17], 32'hC0DE_0011);
    endtask

    task automatic t_high_addr;
        logic seen;
        fresh();
        setup(M_INC, 32'h0, 32'h0000_0012, 4, 1);
        wr(A_CTRL, 1);
        check("R5", "high address half on bus", {mem_req, mem_addr},
              {1'b1, 64'h0000_0012_0000_0000});
        wait_bit(A_STAT1, 16, seen);
        check("R5", "high address transfer complete", seen, 1);
    endtask

    task automatic t_errors;
        logic [31:0] v;
        fresh();
        setup(M_C2M | M_INC, 32'h28, 0, 4, 1);
        wr(A_CTRL, 1);
        rd(A_STAT2, v);
        check("R7", "misaligned start error bits", v, 32'h0002_0000);
        check("R7", "misaligned start moves nothing", {mem_req, buf_rd_ready}, 0);
        fresh();
        setup(M_INC, 32'h0, 0, 4, 0);
        wr(A_CTRL, 1);
        rd(A_STAT2, v);
        check("R7", "zero length error bits", v, 32'h0001_0000);
        check("R7", "zero length moves nothing", {mem_req, buf_wr_valid}, 0);
    endtask

    task automatic t_disabled;
        logic [31:0] v;
        fresh();
        wr(A_XMODE, 0);
        setup(M_C2M | M_INC, 32'h20, 0, 4, 1);
        wr(A_CTRL, 1);
        check("R6", "start ignored when disabled", {mem_req, buf_rd_ready}, 0);
        repeat (3) @(negedge clk);
        rd(A_STAT1, v); check("R6", "no completion when disabled", v, 0);
        check("R6", "no buffer words taken", src_idx, 0);
        wr(A_XMODE, 32'h2);
    endtask

    task automatic t_timing;
        logic [31:0] v; logic [63:0] a0;
        fresh();
        gnt_en = 1'b0;
        setup(M_C2M | M_INC, 32'h30, 0, 4, 1);
        wr(A_CTRL, 1);
        repeat (3) @(negedge clk);
        a0 = mem_addr;
        rd(A_STAT1, v);
        check("R9", "legacy flag before completion", v[17], 1);
        check("R8", "no completion before grant", v[20], 0);
        repeat (2) @(negedge clk);
        check("R13", "request and address held", {mem_req, mem_addr}, {1'b1, a0});
        wr(A_CTRL, 1);
        check("R6", "start while busy ignored, still waiting", {mem_req, mem_we}, 2'b11);
        gnt_en = 1'b1;
        @(negedge clk);
        gnt_en = 1'b0;
        rd(A_STAT1, v);
        check("R8", "completion one cycle after grant", v[20], 1);
        check("R8", "written word", mem[12], 32'hA000_0000);
        gnt_en = 1'b1;
    endtask

    task automatic t_sticky_irq;
        logic [31:0] v; logic seen;
        fresh();
        setup(M_C2M | M_INC, 32'h20, 0, 4, 1);
        wr(A_CTRL, 1);
        wait_bit(A_STAT1, 20, seen);
        check("R11", "all masked keeps irq low", dma_irq, 0);
        wr(A_MASK1, ~32'h0010_0000);
        check("R11", "unmasked completion raises irq", dma_irq, 1);
        wr(A_STAT1, ~32'h0002_0000);
        rd(A_STAT1, v);
        check("R10", "write 0 clears, write 1 keeps", v, 32'h0010_0000);
        wr(A_STAT1, 32'h0);
        rd(A_STAT1, v);
        check("R10", "all cleared by zero write", v, 0);
        check("R11", "irq low once cleared", dma_irq, 0);
        setup(M_INC, 32'h4, 0, 4, 1);
        wr(A_CTRL, 1);
        check("R11", "status2 masked by default", dma_irq, 0);
        wr(A_MASK2, ~32'h0001_0000);
        check("R11", "unmasked error raises irq", dma_irq, 1);
        wr(A_MASK1, 32'hFFFF_FFFF);
        wr(A_MASK2, 32'hFFFF_FFFF);
    endtask

    task automatic t_chan_reset;
        logic [31:0] v; logic seen;
        fresh();
        src_en = 1'b0;
        setup(M_C2M | M_INC, 32'h20, 0, 4, 2);
        wr(A_CTRL, 1);
        check("R12", "waiting for card word", buf_rd_ready, 1);
        wr(A_CHRST, 32'h100);
        check("R12", "other channel reset has no effect", buf_rd_ready, 1);
        wr(A_CHRST, 32'h200);
        check("R12", "own channel reset aborts", {buf_rd_ready, mem_req}, 0);
        src_en = 1'b1;
        repeat (3) @(negedge clk);
        rd(A_STAT1, v);
        check("R12", "no completion after abort", v, 0);
        check("R12", "memory untouched after abort", mem[8], 32'hC0DE_0008);
        wr(A_CTRL, 1);
        wait_bit(A_STAT1, 20, seen);
        check("R12", "restart after abort completes", seen, 1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        wr(A_XMODE, 32'h2);
        t_c2m_inc();
        t_m2c_inc();
        t_fixed();
        t_high_addr();
        t_errors();
        t_disabled();
        t_timing();
        t_sticky_irq();
        t_chan_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule